// File: doc/BRIEF.md
# Link Test Pattern Generator and Checker

This block is the built-in link test engine of one transceiver channel, on the 10-bit parallel data path. A pattern selector picks one of five sources: a short pseudo-random sequence (x^7+x^6+1), a long pseudo-random sequence (x^23+x^18+1), or one of three fixed-frequency words (high, low, mixed). While the test is enabled, the generator drives one word per clock towards the serializer. The checker watches the receive word stream, which may come back through a serial, parallel or external loop.

The checker needs no alignment with the generator. For the pseudo-random sequences it predicts each received bit from bits it received earlier. For the fixed words it compares each word with the one before it. It declares lock after a run of clean words and drops lock when errored words pile up inside a window. While locked it adds the number of mismatching bits to a saturating counter. Management reads that counter, and the read clears it.

Top module: `lt_pattern_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, tx_data is 0, lock is 0 and err_count is 0.
- R2: pat_sel encodes 0 = short PRBS, 1 = long PRBS, 2 = high frequency, 3 = low frequency and 4 = mixed frequency. With test_en low, or with pat_sel at 5, 6 or 7, the cycle after shows tx_data 0 and lock 0, and the checker compares nothing.
- R3: Short PRBS sends x^7+x^6+1, stepped 10 bits per clock from an all-ones state, with the earliest bit in tx_data[9]. The first word after enabling is 10'h008.
- R4: Long PRBS sends x^23+x^18+1 in the same way, from an all-ones 23-bit state.
- R5: High frequency repeats 10'h2AA and low frequency repeats 10'h3E0. Mixed frequency alternates 10'h0FA and 10'h305, starting with 10'h0FA.
- R6: After a restart the checker only stores received words until it holds at least the sequence length of bits: 1 word for the short PRBS and the fixed modes, 3 words for the long PRBS. After that it compares every word. For a PRBS, each bit is predicted from the received bits at the two tap distances. For high and low frequency each word must equal the previous one; for mixed frequency it must be the bitwise complement of the previous one.
- R7: lock rises after 16 consecutive compared words that have no mismatch.
- R8: While locked, lock falls once 8 errored words have been seen within a 16-word window that opens at lock. After that, 16 clean words are needed again.
- R9: Only while lock is 1, each compared word adds its count of mismatching bits to err_count. The count saturates at 16'hFFFF and never wraps.
- R10: An err_rd pulse clears the count. The cycle after a read, err_count shows only that word's increment.
- R11: A change of pat_sel while enabled restarts the generator (the next word is 0, then the new pattern from its start), empties the checker and drops lock.
- R12: Lock is reached whatever the loop latency in words and whatever the bit offset of the returned stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Enables generator and checker |
| pat_sel | input | 3 | Pattern selection code (see R2) |
| tx_data | output | 10 | Generated word, earliest bit in bit 9 |
| rx_data | input | 10 | Received word, earliest bit in bit 9 |
| err_rd | input | 1 | Management read strobe for the error count |
| err_count | output | 16 | Saturating count of mismatching bits |
| lock | output | 1 | Checker lock indication |

## Verification
The hardest state to reach from the ports is a saturated count while lock is still held. Errors must keep arriving often enough to fill 16 bits, but never reach 8 errored words in a 16-word window. The bench reaches it with a high-frequency loop in which one whole word is inverted every eighth word. Each such inversion costs two errored words and twenty counted bits, so saturation comes in a few tens of thousands of cycles with lock held throughout. The bench also shifts the returned stream by a bit offset and adds word delays to show that the checker locks without alignment.

// File: rtl/lt_pkg.sv
package lt_pkg;

  localparam int WORD_W = 10;
  localparam int HIST_W = 23;

  localparam logic [2:0] SEL_PRBS_S = 3'd0;
  localparam logic [2:0] SEL_PRBS_L = 3'd1;
  localparam logic [2:0] SEL_HIGH   = 3'd2;
  localparam logic [2:0] SEL_LOW    = 3'd3;
  localparam logic [2:0] SEL_MIXED  = 3'd4;

  localparam logic [WORD_W-1:0] HIGH_WORD = 10'h2AA;
  localparam logic [WORD_W-1:0] LOW_WORD  = 10'h3E0;
  localparam logic [WORD_W-1:0] MIX_WORD0 = 10'h0FA;
  localparam logic [WORD_W-1:0] MIX_WORD1 = 10'h305;

  localparam int SHORT_LEN = 7;
  localparam int SHORT_TAP = 6;
  localparam int LONG_LEN  = 23;
  localparam int LONG_TAP  = 18;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [HIST_W-1:0] state;
  } gen_step_t;

  function automatic logic sel_valid(input logic [2:0] sel);
    return sel <= SEL_MIXED;
  endfunction

  function automatic logic [1:0] seed_words(input logic [2:0] sel);
    int len;
    len = (sel == SEL_PRBS_L) ? LONG_LEN : ((sel == SEL_PRBS_S) ? SHORT_LEN : WORD_W);
    return 2'((len + WORD_W - 1) / WORD_W);
  endfunction

  // Advance a Fibonacci register by one word; newest bit sits in state[0].
  function automatic gen_step_t prbs_advance(input logic [HIST_W-1:0] s_in,
                                             input logic long_poly);
    gen_step_t r;
    logic [HIST_W-1:0] s;
    logic nb;
    s = s_in;
    r.word = '0;
    for (int k = 0; k < WORD_W; k++) begin
      nb = long_poly ? (s[LONG_LEN-1] ^ s[LONG_TAP-1])
                     : (s[SHORT_LEN-1] ^ s[SHORT_TAP-1]);
      r.word[WORD_W-1-k] = nb;
      s = {s[HIST_W-2:0], nb};
    end
    r.state = s;
    return r;
  endfunction

  // Self-synchronous prediction: each bit is checked against received bits.
  function automatic logic [WORD_W-1:0] prbs_miss(input logic [HIST_W-1:0] hist,
                                                  input logic [WORD_W-1:0] rx,
                                                  input logic long_poly);
    logic [HIST_W+WORD_W-1:0] w;
    logic [WORD_W-1:0] m;
    logic pred;
    w = {hist, rx};
    for (int p = 0; p < WORD_W; p++) begin
      pred = long_poly ? (w[p+LONG_LEN] ^ w[p+LONG_TAP])
                       : (w[p+SHORT_LEN] ^ w[p+SHORT_TAP]);
      m[p] = pred ^ w[p];
    end
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] fixed_miss(input logic [WORD_W-1:0] prev,
                                                   input logic [WORD_W-1:0] rx,
                                                   input logic invert);
    return rx ^ (invert ? ~prev : prev);
  endfunction

  function automatic logic [3:0] ones10(input logic [WORD_W-1:0] v);
    logic [3:0] c;
    c = '0;
    for (int i = 0; i < WORD_W; i++) c = c + 4'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/lt_gen.sv
module lt_gen
  import lt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        sel,
  output logic [WORD_W-1:0] tx_data
);

  logic [HIST_W-1:0] state_q;
  logic              mix_phase_q;
  gen_step_t         step;

  always_comb step = prbs_advance(state_q, sel == SEL_PRBS_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= '1;
      mix_phase_q <= 1'b0;
      tx_data     <= '0;
    end else if (restart) begin
      state_q     <= '1;
      mix_phase_q <= 1'b0;
      tx_data     <= '0;
    end else begin
      case (sel)
        SEL_PRBS_S, SEL_PRBS_L: begin
          tx_data <= step.word;
          state_q <= step.state;
        end
        SEL_HIGH: tx_data <= HIGH_WORD;
        SEL_LOW:  tx_data <= LOW_WORD;
        SEL_MIXED: begin
          tx_data     <= mix_phase_q ? MIX_WORD1 : MIX_WORD0;
          mix_phase_q <= ~mix_phase_q;
        end
        default: tx_data <= '0;
      endcase
    end
  end

  // The shift register may never hold all zeros in a PRBS mode.
  assert_state_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_PRBS_S) |-> (state_q[SHORT_LEN-1:0] != '0));
  assert_state_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_PRBS_L) |-> (state_q != '0));

endmodule

// File: rtl/lt_chk.sv
module lt_chk
  import lt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] rx_data,
  output logic              cmp_valid,
  output logic              word_bad,
  output logic [3:0]        miss_cnt
);

  logic [HIST_W-1:0] hist_q;
  logic [1:0]        seed_q;
  logic              seeded;
  logic [WORD_W-1:0] miss_vec;

  assign seeded = (seed_q == seed_words(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      seed_q <= '0;
    end else if (restart) begin
      hist_q <= '0;
      seed_q <= '0;
    end else begin
      hist_q <= {hist_q[HIST_W-WORD_W-1:0], rx_data};
      if (!seeded) seed_q <= seed_q + 2'd1;
    end
  end

  always_comb begin
    case (sel)
      SEL_PRBS_S: miss_vec = prbs_miss(hist_q, rx_data, 1'b0);
      SEL_PRBS_L: miss_vec = prbs_miss(hist_q, rx_data, 1'b1);
      SEL_MIXED:  miss_vec = fixed_miss(hist_q[WORD_W-1:0], rx_data, 1'b1);
      default:    miss_vec = fixed_miss(hist_q[WORD_W-1:0], rx_data, 1'b0);
    endcase
  end

  assign cmp_valid = !restart && seeded;
  assign miss_cnt  = cmp_valid ? ones10(miss_vec) : 4'd0;
  assign word_bad  = (miss_cnt != 4'd0);

  // A compared word is always preceded by at least one stored seed word.
  assert_seed_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> !$past(restart));
  assert_miss_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt <= 4'(WORD_W));

endmodule

// File: rtl/lt_lock.sv
module lt_lock #(
  parameter int LOCK_GOOD = 16,
  parameter int DROP_BAD  = 8,
  parameter int WIN_LEN   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cmp_valid,
  input  logic word_bad,
  output logic locked
);

  localparam int RUN_W = $clog2(LOCK_GOOD + 1);
  localparam int BAD_W = $clog2(DROP_BAD + 1);
  localparam int WIN_W = $clog2(WIN_LEN) < 1 ? 1 : $clog2(WIN_LEN);

  logic [RUN_W-1:0] run_q;
  logic [BAD_W-1:0] bad_q;
  logic [WIN_W-1:0] win_q;
  logic             lock_gain;
  logic             lock_loss;
  logic             win_end;

  assign lock_gain = !locked && cmp_valid && !word_bad && (run_q == RUN_W'(LOCK_GOOD - 1));
  assign lock_loss = locked && cmp_valid && word_bad && (bad_q == BAD_W'(DROP_BAD - 1));
  assign win_end   = locked && cmp_valid && (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      bad_q  <= '0;
      win_q  <= '0;
      locked <= 1'b0;
    end else if (restart) begin
      run_q  <= '0;
      bad_q  <= '0;
      win_q  <= '0;
      locked <= 1'b0;
    end else if (cmp_valid) begin
      if (locked) begin
        if (lock_loss) begin
          locked <= 1'b0;
          run_q  <= '0;
          bad_q  <= '0;
          win_q  <= '0;
        end else if (win_end) begin
          bad_q <= '0;
          win_q <= '0;
        end else begin
          win_q <= win_q + WIN_W'(1);
          bad_q <= bad_q + BAD_W'(word_bad);
        end
      end else if (word_bad) begin
        run_q <= '0;
      end else if (lock_gain) begin
        locked <= 1'b1;
        run_q  <= '0;
        bad_q  <= '0;
        win_q  <= '0;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  assert_gain_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_valid && !word_bad));
  assert_loss_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(restart)) |-> $past(cmp_valid && word_bad));
  assert_bad_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q < BAD_W'(DROP_BAD));

endmodule

// File: rtl/lt_errcnt.sv
module lt_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             cmp_valid,
  input  logic [3:0]       miss_cnt,
  input  logic             rd,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]       add;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  assign add  = (locked && cmp_valid) ? miss_cnt : 4'd0;
  assign base = rd ? '0 : count;
  assign sum  = {1'b0, base} + (CNT_W+1)'(add);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  assert_hold_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(locked) && !$past(rd)) |-> $stable(count));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> (count >= $past(count)));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !(locked && cmp_valid)) |=> (count == '0));

endmodule

// File: rtl/lt_pattern_unit.sv
module lt_pattern_unit
  import lt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LOCK_GOOD = 16,
  parameter int DROP_BAD  = 8,
  parameter int WIN_LEN   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic [2:0]       pat_sel,
  output logic [9:0]       tx_data,
  input  logic [9:0]       rx_data,
  input  logic             err_rd,
  output logic [CNT_W-1:0] err_count,
  output logic             lock
);

  logic [2:0] sel_q;
  logic       restart;
  logic       cmp_valid;
  logic       word_bad;
  logic [3:0] miss_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_PRBS_S;
    else        sel_q <= pat_sel;
  end

  assign restart = !test_en || !sel_valid(pat_sel) || (pat_sel != sel_q);

  lt_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (pat_sel),
    .tx_data (tx_data)
  );

  lt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .sel       (pat_sel),
    .rx_data   (rx_data),
    .cmp_valid (cmp_valid),
    .word_bad  (word_bad),
    .miss_cnt  (miss_cnt)
  );

  lt_lock #(
    .LOCK_GOOD (LOCK_GOOD),
    .DROP_BAD  (DROP_BAD),
    .WIN_LEN   (WIN_LEN)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .cmp_valid (cmp_valid),
    .word_bad  (word_bad),
    .locked    (lock)
  );

  lt_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (lock),
    .cmp_valid (cmp_valid),
    .miss_cnt  (miss_cnt),
    .rd        (err_rd),
    .count     (err_count)
  );

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (tx_data == '0 && !lock));
  assert_switch_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && pat_sel != sel_q) |=> !lock);

endmodule

// File: tb/tb_lt_pattern_unit.sv
module tb_lt_pattern_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_en = 1'b0;
  logic [2:0]  pat_sel = 3'd0;
  logic [9:0]  tx_data;
  logic [9:0]  rx_data = '0;
  logic        err_rd = 1'b0;
  logic [15:0] err_count;
  logic        lock;

  always #10 clk = ~clk;

  lt_pattern_unit dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .pat_sel(pat_sel),
    .tx_data(tx_data), .rx_data(rx_data), .err_rd(err_rd),
    .err_count(err_count), .lock(lock)
  );

  int total = 0;
  int bad = 0;
  int ncyc = 0;
  bit live = 0;

  // bench-side controls applied at each falling edge
  bit       en_v = 0;
  bit [2:0] sel_v = 0;
  bit       rd_v = 0;
  bit [9:0] mask_v = 0;
  int       dly_v = 0;
  int       rot_v = 0;
  logic [9:0] txh[$];

  // reference model state
  bit [2:0]   m_selq;
  logic [9:0] m_tx;
  bit         m_lock;
  int         m_cnt, m_run, m_win, m_bad;
  bit         m_ph;
  bit         gq[$];
  bit         rq[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    gq.delete();
    for (int i = 0; i < 23; i++) gq.push_back(1'b1);
    rq.delete();
    m_tx = '0; m_lock = 0; m_run = 0; m_win = 0; m_bad = 0; m_ph = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_selq = 0; m_cnt = 0;
    end else begin
      bit rs, lk0, cmpv;
      int e, lag, tap, c;
      logic [9:0] w;
      rs = !test_en || pat_sel > 4 || pat_sel != m_selq;
      m_selq = pat_sel;
      lk0 = m_lock; e = 0; cmpv = 0;
      if (rs) model_clear();
      else begin
        if (pat_sel < 2) begin
          lag = pat_sel == 0 ? 7 : 23;
          tap = pat_sel == 0 ? 6 : 18;
          for (int k = 0; k < 10; k++) begin
            bit b;
            b = gq[gq.size()-lag] ^ gq[gq.size()-tap];
            gq.push_back(b);
            w[9-k] = b;
          end
          while (gq.size() > 40) void'(gq.pop_front());
          m_tx = w;
        end else if (pat_sel == 2) m_tx = 10'b1010101010;
        else if (pat_sel == 3) m_tx = 10'b1111100000;
        else begin
          m_tx = m_ph ? 10'b1100000101 : 10'b0011111010;
          m_ph = !m_ph;
        end
        lag = pat_sel == 0 ? 7 : (pat_sel == 1 ? 23 : 10);
        tap = pat_sel == 0 ? 6 : 18;
        cmpv = rq.size() >= lag;
        for (int k = 0; k < 10; k++) begin
          bit b, p;
          b = rx_data[9-k];
          if (cmpv) begin
            if (pat_sel < 2) p = rq[rq.size()-lag] ^ rq[rq.size()-tap];
            else if (pat_sel == 4) p = !rq[rq.size()-10];
            else p = rq[rq.size()-10];
            if (p != b) e++;
          end
          rq.push_back(b);
        end
        while (rq.size() > 40) void'(rq.pop_front());
        if (cmpv) begin
          if (m_lock) begin
            m_win++;
            if (e != 0) m_bad++;
            if (m_bad == 8) begin m_lock = 0; m_run = 0; m_win = 0; m_bad = 0; end
            else if (m_win == 16) begin m_win = 0; m_bad = 0; end
          end else begin
            if (e == 0) m_run++; else m_run = 0;
            if (m_run >= 16) begin m_lock = 1; m_run = 0; m_win = 0; m_bad = 0; end
          end
        end
      end
      c = err_rd ? 0 : m_cnt;
      if (lk0 && cmpv) c += e;
      if (c > 65535) c = 65535;
      m_cnt = c;
    end
  end

  task automatic cyc();
    string treq;
    int idx;
    logic [19:0] comb;
    @(negedge clk);
    if (live) begin
      case (pat_sel)
        3'd0: treq = "R3";
        3'd1: treq = "R4";
        3'd2, 3'd3, 3'd4: treq = "R5";
        default: treq = "R2";
      endcase
      if (!test_en) treq = "R2";
      chk(treq, "tx word", tx_data, m_tx);
      chk("R6/R7/R8", "lock", lock, m_lock);
      chk("R9", "count", err_count, m_cnt);
    end
    txh.push_back(tx_data);
    while (txh.size() > 8) void'(txh.pop_front());
    idx = txh.size() - 1 - dly_v;
    if (idx >= 1) begin
      comb = {txh[idx-1], txh[idx]};
      rx_data = comb[19-rot_v -: 10] ^ mask_v;
    end else rx_data = mask_v;
    test_en = en_v; pat_sel = sel_v; err_rd = rd_v;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog cycles actual=%0d expected=<150000", ncyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tx in reset", tx_data, 10'h000);
    chk("R1", "lock in reset", lock, 1'b0);
    chk("R1", "count in reset", err_count, 16'h0000);
    rst_n = 1'b1;
    live = 1;
    cyc();
    chk("R1", "tx after reset", tx_data, 10'h000);

    // R3: first short PRBS word, then lock through loopback
    en_v = 1; sel_v = 0;
    cyc(); cyc();
    chk("R3", "first word", tx_data, 10'h008);
    run(30);
    chk("R7", "short PRBS lock", lock, 1'b1);

    // R9/R10: single bit error gives three counted mismatches
    rd_v = 1; cyc(); rd_v = 0;
    mask_v = 10'h200; cyc(); mask_v = 0;
    run(4);
    chk("R9", "single error count", err_count, 16'd3);
    rd_v = 1; cyc(); rd_v = 0; cyc();
    chk("R10", "cleared on read", err_count, 16'd0);

    // R8: eight errored words drop lock, then relock
    mask_v = 10'h001; run(8); mask_v = 0;
    run(2);
    chk("R8", "lock dropped", lock, 1'b0);
    run(30);
    chk("R8", "relocked", lock, 1'b1);

    // R11: switch to low frequency clears lock, restarts generator
    sel_v = 3; cyc(); cyc();
    chk("R11", "lock after switch", lock, 1'b0);
    chk("R11", "restart word", tx_data, 10'h000);
    cyc();
    chk("R5", "low word", tx_data, 10'h3E0);
    run(25);
    chk("R6", "low freq lock", lock, 1'b1);

    // R5: mixed frequency words and complement checking
    sel_v = 4; cyc(); cyc(); cyc();
    chk("R5", "mixed word A", tx_data, 10'h0FA);
    cyc();
    chk("R5", "mixed word B", tx_data, 10'h305);
    run(25);
    chk("R6", "mixed freq lock", lock, 1'b1);

    // R4/R12: long PRBS with word delay and bit offset
    sel_v = 1; dly_v = 3; rot_v = 4;
    run(45);
    chk("R12", "long PRBS lock offset", lock, 1'b1);
    chk("R4", "long PRBS lock", lock, 1'b1);

    // R2: invalid code and disabled
    sel_v = 6; cyc(); cyc();
    chk("R2", "invalid code tx", tx_data, 10'h000);
    chk("R2", "invalid code lock", lock, 1'b0);
    sel_v = 2; en_v = 0; cyc(); cyc();
    chk("R2", "disabled tx", tx_data, 10'h000);

    // R9: saturation in high frequency mode while lock is held
    en_v = 1; dly_v = 0; rot_v = 0;
    run(25);
    chk("R7", "high freq lock", lock, 1'b1);
    for (int i = 0; i < 40000 && err_count != 16'hFFFF; i++) begin
      mask_v = (i % 8 == 0) ? 10'h3FF : 10'h000;
      cyc();
    end
    mask_v = 0;
    run(4);
    chk("R9", "saturated", err_count, 16'hFFFF);
    chk("R9", "lock held at saturation", lock, 1'b1);
    rd_v = 1; cyc(); rd_v = 0; cyc();
    chk("R10", "clear after saturation", err_count, 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule